// File: doc/BRIEF.md
# Video Sync Free-Run Monitor

This block watches the horizontal and vertical sync strobes of an incoming video stream, measures how many sampling clocks each line lasts and how many lines fall between vertical syncs, and compares both against programmed expectations. When either measurement falls outside its tolerance window, it raises a free-run request. A downstream timing generator uses that request to switch from locked timing to its own free-running timing. The last measured counts and separate per-measurement error flags are also reported, so the cause of the request can be seen at a glance.

Each sync input is sampled on the sampling clock, and only its rising edge counts. A measurement is taken on the clock edge that first samples a sync strobe high, and its results are visible from the next cycle onward. In interlaced mode the vertical count is one field, and the programmed value is the frame total. The request drops only after a run of clean measurements on both axes, so a single good line cannot cancel it. All ports are plain control and status signals. The block carries no data stream, so no handshake applies.

Top module: `vsync_freerun_mon`

## Requirements
- R1: `meas_line_len` holds the number of sampling clocks between the last two rising edges of `hs`. The first `hs` rising edge after reset only starts counting and produces no measurement.
- R2: `line_err` is 1 when the absolute difference between a measured line length and `cfg_line_len` is strictly greater than `cfg_line_tol`. A difference equal to the tolerance counts as good.
- R3: `meas_frame_lines` holds the number of `hs` rising edges seen between the last two rising edges of `vs`. The first `vs` rising edge after reset produces no measurement.
- R4: With `cfg_interlaced` = 0, `frame_err` is 1 when the absolute difference between the measured line count and `cfg_frame_len` is strictly greater than `cfg_frame_tol`.
- R5: With `cfg_interlaced` = 1, a field is good when it is within `cfg_frame_tol` of either floor(`cfg_frame_len`/2) or ceil(`cfg_frame_len`/2). Fields of alternating N and N+1 lines for a frame total of 2N+1 are therefore both accepted.
- R6: `free_run` is 1 in the cycle after any measurement that is out of tolerance.
- R7: `free_run` returns to 0 only once both of these are true: the two most recent line measurements were good, and the two most recent frame measurements were good. A bad line restarts the line run without touching the frame run, and a bad frame does the same the other way round.
- R8: The sample counter saturates at 2^LINE_W-1 (8191 by default). On reaching that value without an `hs` edge, the block sets `meas_line_len` to 8191 and sets both `line_err` and `free_run`.
- R9: The line counter saturates at 2^FRAME_W-1 (2047 by default), so a lost `vs` yields a measurement of 2047 rather than a wrapped value.
- R10: After reset `free_run` is 1, both error flags are 0 and both measured counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs | input | 1 | Horizontal sync strobe, rising edge is used |
| vs | input | 1 | Vertical sync strobe, rising edge is used |
| cfg_line_len | input | LINE_W | Expected sampling clocks per line |
| cfg_line_tol | input | TOL_W | Allowed line-length deviation |
| cfg_frame_len | input | FRAME_W | Expected lines per frame |
| cfg_frame_tol | input | TOL_W | Allowed line-count deviation |
| cfg_interlaced | input | 1 | 1 = interlaced input, 0 = progressive |
| free_run | output | 1 | Request to the timing generator to free-run |
| line_err | output | 1 | Last line measurement out of tolerance |
| frame_err | output | 1 | Last frame or field measurement out of tolerance |
| meas_line_len | output | LINE_W | Last measured line length |
| meas_frame_lines | output | FRAME_W | Last measured lines per frame or field |

## Verification
A counter that is off by one shows up in `meas_line_len` or `meas_frame_lines` one cycle after the next sync edge. It also moves the threshold boundary, which the equal-to-tolerance cases catch. A wrong run counter shows as `free_run` dropping one measurement too early or too late, and the bench samples after each line to see it. A broken saturation path shows either as a wrapped small count or as a missing error after a long stretch without sync, which takes about 8191 cycles for lines and 2047 lines for frames to reach.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int CMP_W = 16;
  typedef logic [CMP_W-1:0] cmp_t;

  typedef struct packed {
    logic valid;
    logic bad;
  } meas_ev_t;

  function automatic cmp_t abs_gap(cmp_t a, cmp_t b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction
endpackage

// File: rtl/vsm_rise_det.sv
module vsm_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/vsm_line_meter.sv
module vsm_line_meter
  import vsm_pkg::*;
#(
  parameter int LINE_W = 13,
  parameter int TOL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_rise,
  input  logic [LINE_W-1:0] exp_len,
  input  logic [TOL_W-1:0]  tol,
  output meas_ev_t          ev,
  output logic [LINE_W-1:0] meas_len,
  output logic              err
);
  localparam logic [LINE_W-1:0] CMAX = '1;
  localparam logic [LINE_W-1:0] ONE  = LINE_W'(1);

  logic [LINE_W-1:0] cnt;
  logic              seen;
  logic              timeout;
  cmp_t              gap;

  assign timeout = !hs_rise && (cnt == CMAX - ONE);
  assign gap     = abs_gap(cmp_t'(cnt), cmp_t'(exp_len));
  assign ev.valid = (hs_rise && seen) || timeout;
  assign ev.bad   = timeout || (gap > cmp_t'(tol));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      seen     <= 1'b0;
      meas_len <= '0;
      err      <= 1'b0;
    end else begin
      if (hs_rise)          cnt <= ONE;
      else if (cnt != CMAX) cnt <= cnt + ONE;
      if (hs_rise) seen <= 1'b1;
      if (ev.valid) begin
        meas_len <= timeout ? CMAX : cnt;
        err      <= ev.bad;
      end
    end
  end
endmodule

// File: rtl/vsm_frame_meter.sv
module vsm_frame_meter
  import vsm_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int TOL_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_rise,
  input  logic               vs_rise,
  input  logic [FRAME_W-1:0] exp_lines,
  input  logic [TOL_W-1:0]   tol,
  input  logic               interlaced,
  output meas_ev_t           ev,
  output logic [FRAME_W-1:0] meas_lines,
  output logic               err
);
  localparam logic [FRAME_W-1:0] CMAX = '1;
  localparam logic [FRAME_W-1:0] ONE  = FRAME_W'(1);

  logic [FRAME_W-1:0] cnt;
  logic               seen;
  cmp_t               half_lo, half_hi, gap_full, gap_lo, gap_hi, tol_c;
  logic               off_prog, off_il;

  assign half_lo  = cmp_t'(exp_lines >> 1);
  assign half_hi  = half_lo + cmp_t'(exp_lines[0]);
  assign tol_c    = cmp_t'(tol);
  assign gap_full = abs_gap(cmp_t'(cnt), cmp_t'(exp_lines));
  assign gap_lo   = abs_gap(cmp_t'(cnt), half_lo);
  assign gap_hi   = abs_gap(cmp_t'(cnt), half_hi);
  assign off_prog = gap_full > tol_c;
  assign off_il   = (gap_lo > tol_c) && (gap_hi > tol_c);

  assign ev.valid = vs_rise && seen;
  assign ev.bad   = interlaced ? off_il : off_prog;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt        <= '0;
      seen       <= 1'b0;
      meas_lines <= '0;
      err        <= 1'b0;
    end else begin
      if (vs_rise)                      cnt <= hs_rise ? ONE : '0;
      else if (hs_rise && cnt != CMAX)  cnt <= cnt + ONE;
      if (vs_rise) seen <= 1'b1;
      if (ev.valid) begin
        meas_lines <= cnt;
        err        <= ev.bad;
      end
    end
  end
endmodule

// File: rtl/vsync_freerun_mon.sv
module vsync_freerun_mon
  import vsm_pkg::*;
#(
  parameter int LINE_W   = 13,
  parameter int FRAME_W  = 11,
  parameter int TOL_W    = 8,
  parameter int GOOD_RUN = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs,
  input  logic               vs,
  input  logic [LINE_W-1:0]  cfg_line_len,
  input  logic [TOL_W-1:0]   cfg_line_tol,
  input  logic [FRAME_W-1:0] cfg_frame_len,
  input  logic [TOL_W-1:0]   cfg_frame_tol,
  input  logic               cfg_interlaced,
  output logic               free_run,
  output logic               line_err,
  output logic               frame_err,
  output logic [LINE_W-1:0]  meas_line_len,
  output logic [FRAME_W-1:0] meas_frame_lines
);
  localparam int SW = $clog2(GOOD_RUN + 1);
  localparam logic [SW-1:0] RUN_T = SW'(GOOD_RUN);

  logic [1:0] sync_lvl, sync_rise;
  assign sync_lvl = {vs, hs};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    vsm_rise_det u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .lvl  (sync_lvl[g]),
      .rise (sync_rise[g])
    );
  end

  meas_ev_t line_ev, frame_ev;

  vsm_line_meter #(.LINE_W(LINE_W), .TOL_W(TOL_W)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .hs_rise (sync_rise[0]),
    .exp_len (cfg_line_len),
    .tol     (cfg_line_tol),
    .ev      (line_ev),
    .meas_len(meas_line_len),
    .err     (line_err)
  );

  vsm_frame_meter #(.FRAME_W(FRAME_W), .TOL_W(TOL_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .hs_rise   (sync_rise[0]),
    .vs_rise   (sync_rise[1]),
    .exp_lines (cfg_frame_len),
    .tol       (cfg_frame_tol),
    .interlaced(cfg_interlaced),
    .ev        (frame_ev),
    .meas_lines(meas_frame_lines),
    .err       (frame_err)
  );

  logic [SW-1:0] line_run, frame_run, line_run_n, frame_run_n;
  logic          any_bad, fr_n;

  function automatic logic [SW-1:0] run_step(meas_ev_t e, logic [SW-1:0] cur);
    if (!e.valid)     return cur;
    if (e.bad)        return '0;
    if (cur == RUN_T) return cur;
    return cur + SW'(1);
  endfunction

  always_comb begin
    line_run_n  = run_step(line_ev, line_run);
    frame_run_n = run_step(frame_ev, frame_run);
    any_bad     = (line_ev.valid && line_ev.bad) || (frame_ev.valid && frame_ev.bad);
    if (any_bad)                                         fr_n = 1'b1;
    else if (line_run_n == RUN_T && frame_run_n == RUN_T) fr_n = 1'b0;
    else                                                 fr_n = free_run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_run  <= '0;
      frame_run <= '0;
      free_run  <= 1'b1;
    end else begin
      line_run  <= line_run_n;
      frame_run <= frame_run_n;
      free_run  <= fr_n;
    end
  end
endmodule

// File: rtl/vsync_freerun_mon_chk.sv
module vsync_freerun_mon_chk #(
  parameter int LINE_W  = 13,
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hs,
  input logic               vs,
  input logic               free_run,
  input logic               line_err,
  input logic               frame_err,
  input logic [LINE_W-1:0]  meas_line_len,
  input logic [FRAME_W-1:0] meas_frame_lines
);
  localparam logic [LINE_W-1:0] LMAX = '1;

  AST_ERR_HOLDS_FREERUN: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err || frame_err) |-> free_run); // R6

  AST_RELEASE_ON_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(free_run) |-> ($past(hs) || $past(vs))); // R7

  AST_LINE_MEAS_ON_HS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_line_len) |-> ($past(hs) || meas_line_len == LMAX)); // R1

  AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(meas_line_len) && meas_line_len == LMAX) |-> line_err); // R8

  AST_FRAME_MEAS_ON_VS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(meas_frame_lines) |-> $past(vs)); // R3
endmodule

bind vsync_freerun_mon vsync_freerun_mon_chk #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .hs              (hs),
  .vs              (vs),
  .free_run        (free_run),
  .line_err        (line_err),
  .frame_err       (frame_err),
  .meas_line_len   (meas_line_len),
  .meas_frame_lines(meas_frame_lines)
);

// File: tb/tb_vsync_freerun_mon.sv
module tb_vsync_freerun_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hs = 1'b0, vs = 1'b0;
  logic [12:0] cfg_line_len = '0;
  logic [7:0]  cfg_line_tol = '0;
  logic [10:0] cfg_frame_len = '0;
  logic [7:0]  cfg_frame_tol = '0;
  logic        cfg_interlaced = 1'b0;
  logic        free_run, line_err, frame_err;
  logic [12:0] meas_line_len;
  logic [10:0] meas_frame_lines;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  vsync_freerun_mon dut (
    .clk(clk), .rst_n(rst_n), .hs(hs), .vs(vs),
    .cfg_line_len(cfg_line_len), .cfg_line_tol(cfg_line_tol),
    .cfg_frame_len(cfg_frame_len), .cfg_frame_tol(cfg_frame_tol),
    .cfg_interlaced(cfg_interlaced),
    .free_run(free_run), .line_err(line_err), .frame_err(frame_err),
    .meas_line_len(meas_line_len), .meas_frame_lines(meas_frame_lines)
  );

  typedef struct packed {
    logic        il;
    logic [12:0] lexp;
    logic [7:0]  ltol;
    logic [10:0] fexp;
    logic [7:0]  ftol;
    logic [12:0] lact;
    logic [10:0] fact;
    logic        efr, ele, efe;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd20, 11'd10, 1'b0, 1'b0, 1'b0},
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd22, 11'd10, 1'b0, 1'b0, 1'b0},
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd23, 11'd10, 1'b1, 1'b1, 1'b0},
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd17, 11'd10, 1'b1, 1'b1, 1'b0},
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd20, 11'd12, 1'b1, 1'b0, 1'b1},
    '{1'b0, 13'd20, 8'd2, 11'd10, 8'd1, 13'd20, 11'd11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 13'd20, 8'd2, 11'd21, 8'd0, 13'd20, 11'd10, 1'b0, 1'b0, 1'b0},
    '{1'b1, 13'd20, 8'd2, 11'd21, 8'd0, 13'd20, 11'd11, 1'b0, 1'b0, 1'b0},
    '{1'b1, 13'd20, 8'd2, 11'd21, 8'd0, 13'd20, 11'd12, 1'b1, 1'b0, 1'b1},
    '{1'b1, 13'd20, 8'd2, 11'd20, 8'd0, 13'd20, 11'd11, 1'b1, 1'b0, 1'b1},
    '{1'b0, 13'd20, 8'd2, 11'd21, 8'd0, 13'd20, 11'd10, 1'b1, 1'b0, 1'b1},
    '{1'b0, 13'd20, 8'd0, 11'd10, 8'd0, 13'd20, 11'd10, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic il, input int le, input int lt, input int fe, input int ft);
    cfg_interlaced = il;
    cfg_line_len   = 13'(le);
    cfg_line_tol   = 8'(lt);
    cfg_frame_len  = 11'(fe);
    cfg_frame_tol  = 8'(ft);
  endtask

  // hs rises at the first edge; vs, when asked, one cycle later
  task automatic pulse_line(input int len, input logic with_vs);
    hs = 1'b1; vs = 1'b0;
    @(negedge clk);
    hs = 1'b0; vs = with_vs;
    @(negedge clk);
    vs = 1'b0;
    repeat (len - 2) @(negedge clk);
  endtask

  task automatic run_frame(input int nlines, input int len);
    for (int i = 0; i < nlines; i++) pulse_line(len, i == 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R10: reset state
    cfg(1'b0, 20, 2, 10, 1);
    do_reset();
    chk("R10 free_run", free_run, 1);
    chk("R10 line_err", line_err, 0);
    chk("R10 frame_err", frame_err, 0);
    chk("R10 meas_line", meas_line_len, 0);
    chk("R10 meas_frame", meas_frame_lines, 0);

    // table walk: four frames plus one trailing line per vector
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v].il, VEC[v].lexp, VEC[v].ltol, VEC[v].fexp, VEC[v].ftol);
      do_reset();
      for (int f = 0; f < 4; f++) run_frame(VEC[v].fact, VEC[v].lact);
      pulse_line(VEC[v].lact, 1'b0);
      chk("R1 meas_line", meas_line_len, VEC[v].lact);
      chk("R3 meas_frame", meas_frame_lines, VEC[v].fact);
      chk("R2 line_err", line_err, VEC[v].ele);
      chk(VEC[v].il ? "R5 frame_err" : "R4 frame_err", frame_err, VEC[v].efe);
      chk("R6 free_run", free_run, VEC[v].efr);
    end

    // R7: frame run needs two good frames
    cfg(1'b0, 20, 2, 10, 1);
    do_reset();
    run_frame(10, 20); run_frame(10, 20);
    chk("R7 one good frame keeps free_run", free_run, 1);
    run_frame(10, 20);
    chk("R7 two good frames release", free_run, 0);

    // R7: one bad line restarts the line run
    pulse_line(20, 1'b0);
    pulse_line(25, 1'b0);
    pulse_line(20, 1'b0);
    chk("R6 bad line sets free_run", free_run, 1);
    chk("R2 bad line flag", line_err, 1);
    chk("R1 bad line length", meas_line_len, 25);
    pulse_line(20, 1'b0);
    chk("R7 one good line keeps free_run", free_run, 1);
    chk("R2 good line clears flag", line_err, 0);
    pulse_line(20, 1'b0);
    chk("R7 two good lines release", free_run, 0);

    // R8: lost horizontal sync saturates the sample counter
    hs = 1'b0;
    repeat (8200) @(negedge clk);
    chk("R8 meas_line saturated", meas_line_len, 8191);
    chk("R8 line_err", line_err, 1);
    chk("R8 free_run", free_run, 1);

    // R5: alternating fields of 10 and 11 lines, frame total 21
    cfg(1'b1, 20, 2, 21, 0);
    do_reset();
    for (int f = 0; f < 5; f++) run_frame((f % 2 == 0) ? 10 : 11, 20);
    chk("R5 alternating fields frame_err", frame_err, 0);
    chk("R5 alternating fields free_run", free_run, 0);

    // R9: lost vertical sync saturates the line counter
    cfg(1'b0, 8, 0, 10, 0);
    do_reset();
    pulse_line(8, 1'b1);
    for (int i = 0; i < 2100; i++) pulse_line(8, 1'b0);
    pulse_line(8, 1'b1);
    chk("R9 meas_frame saturated", meas_frame_lines, 2047);
    chk("R9 frame_err", frame_err, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule